// File: doc/BRIEF.md
# NAND flash command sequencer

This block drives the raw bus of an asynchronous 8-bit NAND flash device. Software fills a small register file with two opcodes, up to eight address bytes, a 32-bit data word, strobe timing and a ready-check pattern. It then writes a control word whose top bit launches the sequence. The control word picks which phases run. The phases are a first opcode, 1 to 16 address cycles, a programmed-I/O transfer of 1 to 4 bytes in either direction, a second opcode, and a ready check. The second opcode goes either before or after the data.

The block generates chip enable, the command and address latch enables, the write and read strobes and the bidirectional byte bus, with cycle counts taken from the timing register. The ready check issues a status opcode and reads one byte. It repeats after an idle gap until the masked byte matches the expected value. When the sequence ends the block sets a sticky done flag. Software clears the flag by writing one to it, and the flag can raise an interrupt line.

Register word index (reg_addr_i): 0 control, 1 first opcode [7:0], 2 second opcode [7:0], 3 address bytes 0-3, 4 address bytes 4-7, 5 data, 6 timing, 7 ready pattern, 8 interrupt status, 9 interrupt enable.

Top module: `nand_seq`

## Requirements
- R1: After reset ce_no is 8'hFF, we_no and re_no are 1, and cle_o, ale_o and io_oe_o are 0. The control word reads 0 and the ready pattern register (index 7) reads 32'h0070_0000.
- R2: Writing the control word with bit 31 set while idle starts a sequence. Control bit 31 reads 1 while the sequence runs and 0 after it ends. Phase enables are bit 30 (first opcode), bit 29 (address), bit 25 (second opcode) and bit 16 (ready check). The data phase needs bit 28 together with bit 27 (transmit) or bit 26 (receive). A phase whose enable is 0 is skipped.
- R3: Each written byte holds we_no low for timing[11:8]+1 cycles, then high for timing[13:12]+1 cycles, with io_oe_o set for the whole byte. cle_o is high during opcode bytes and ale_o during address bytes. we_no and re_no are never low together.
- R4: The number of address cycles is control[3:0]+1. Bytes go out least significant first: bytes 0-3 from index 3, bytes 4-7 from index 4, and zero for cycles beyond the eighth.
- R5: With control bit 24 clear, the phases run in this order: first opcode, address, second opcode, ready check, data.
- R6: With control bit 24 set, the phases run in this order: first opcode, address, data, second opcode, ready check.
- R7: A transmit sends control[23:20]+1 bytes, capped at 4, from the data register, lowest byte first.
- R8: A receive holds re_no low for timing[3:0]+1 cycles and high for timing[7:4]+1 cycles per byte. It samples io_i in the last low cycle and stores byte k into data bits [8k+7:8k]. Lanes it does not receive keep their values.
- R9: The ready check first idles for timing[27:24]+1 cycles with CE asserted. It then writes the status opcode from pattern[23:16] and reads one byte. It finishes when (byte & pattern[15:8]) == pattern[7:0]; otherwise it idles pattern[31:24]+1 cycles and repeats.
- R10: Completion sets interrupt status bit 5 (index 8). Writing one to that bit clears it. irq_o equals status bit 5 AND enable bit 5 AND enable bit 0 (index 9).
- R11: Register writes to indices 0-7 while a sequence runs are ignored.
- R12: A control word with only the start bit set raises done within two cycles and toggles no strobe.
- R13: While busy, ce_no equals the inverse of control[15:8]. When idle, ce_no is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on index) |
| ce_no | output | 8 | Chip enables, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_no | output | 1 | Write strobe, active low |
| re_no | output | 1 | Read strobe, active low |
| io_o | output | 8 | Byte bus out |
| io_oe_o | output | 1 | Byte bus drive enable |
| io_i | input | 8 | Byte bus in |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is a ready poll that loops several times while software tries to rewrite the control, data and timing registers. The bench models the device with a short list of status bytes that advances on every rising read strobe. The first bytes fail the mask compare and a later one passes, so the poll is held open for several rounds. During those rounds the bench writes the registers and reads them back. It then counts the logged status opcodes and reads to confirm both the number of rounds and that the writes had no effect. The two phase orders are told apart by the bus event log alone, so a swapped order or a missed byte shows up at the pins.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int IDX_W    = 4;
  localparam int CE_W     = 8;
  localparam int CE_LSB   = 8;

  localparam int B_GO   = 31;
  localparam int B_OP1  = 30;
  localparam int B_ADR  = 29;
  localparam int B_PIO  = 28;
  localparam int B_TX   = 27;
  localparam int B_RX   = 26;
  localparam int B_OP2  = 25;
  localparam int B_AFT  = 24;
  localparam int B_RDY  = 16;
  localparam int B_DONE = 5;

  localparam logic [IDX_W-1:0] RI_CTRL = 4'd0;
  localparam logic [IDX_W-1:0] RI_OP1  = 4'd1;
  localparam logic [IDX_W-1:0] RI_OP2  = 4'd2;
  localparam logic [IDX_W-1:0] RI_ALO  = 4'd3;
  localparam logic [IDX_W-1:0] RI_AHI  = 4'd4;
  localparam logic [IDX_W-1:0] RI_DATA = 4'd5;
  localparam logic [IDX_W-1:0] RI_TIM  = 4'd6;
  localparam logic [IDX_W-1:0] RI_POLL = 4'd7;
  localparam logic [IDX_W-1:0] RI_IST  = 4'd8;
  localparam logic [IDX_W-1:0] RI_IEN  = 4'd9;

  localparam logic [WORD_W-1:0] POLL_RST = 32'h0070_0000;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD1, PH_ADDR, PH_CMD2, PH_DATA, PH_RDY, PH_DONE
  } ph_e;

  typedef enum logic [1:0] {RS_WAIT, RS_CMD, RS_READ, RS_GAP} rs_e;

  // phase order; the after-data flag swaps data ahead of second opcode + ready
  function automatic ph_e ph_succ(ph_e p, logic aft);
    case (p)
      PH_IDLE: return PH_CMD1;
      PH_CMD1: return PH_ADDR;
      PH_ADDR: return aft ? PH_DATA : PH_CMD2;
      PH_CMD2: return PH_RDY;
      PH_RDY:  return aft ? PH_DONE : PH_DATA;
      PH_DATA: return aft ? PH_CMD2 : PH_DONE;
      default: return PH_DONE;
    endcase
  endfunction

  function automatic logic ph_on(ph_e p, logic [WORD_W-1:0] w);
    case (p)
      PH_CMD1: return w[B_OP1];
      PH_ADDR: return w[B_ADR];
      PH_CMD2: return w[B_OP2];
      PH_DATA: return w[B_PIO] & (w[B_TX] | w[B_RX]);
      PH_RDY:  return w[B_RDY];
      PH_DONE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic ph_e ph_next(ph_e p, logic [WORD_W-1:0] w);
    ph_e  q;
    logic hit;
    q   = p;
    hit = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (!hit) begin
        q   = ph_succ(q, w[B_AFT]);
        hit = ph_on(q, w);
      end
    end
    return q;
  endfunction
endpackage

// File: rtl/nand_seq_regs.sv
module nand_seq_regs
  import nand_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              rx_we_i,
  input  logic [1:0]        rx_lane_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic              start_o,
  output logic [WORD_W-1:0] ctrl_o,
  output logic [BYTE_W-1:0] op1_o,
  output logic [BYTE_W-1:0] op2_o,
  output logic [WORD_W-1:0] alo_o,
  output logic [WORD_W-1:0] ahi_o,
  output logic [WORD_W-1:0] data_o,
  output logic [WORD_W-1:0] tim_o,
  output logic [WORD_W-1:0] poll_o,
  output logic              irq_o
);
  logic              cfg_we;
  logic [WORD_W-1:0] ctrl_q, ien_q;
  logic              done_q;
  logic              unused_ien;

  assign cfg_we  = wr_i && !busy_i;
  assign start_o = cfg_we && addr_i == RI_CTRL && wdata_i[B_GO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0; op1_o <= '0; op2_o <= '0; alo_o <= '0; ahi_o <= '0;
      data_o <= '0; tim_o <= '0; poll_o <= POLL_RST; ien_q <= '0;
    end else begin
      if (cfg_we) begin
        case (addr_i)
          RI_CTRL: ctrl_q <= {1'b0, wdata_i[WORD_W-2:0]};
          RI_OP1:  op1_o  <= wdata_i[BYTE_W-1:0];
          RI_OP2:  op2_o  <= wdata_i[BYTE_W-1:0];
          RI_ALO:  alo_o  <= wdata_i;
          RI_AHI:  ahi_o  <= wdata_i;
          RI_DATA: data_o <= wdata_i;
          RI_TIM:  tim_o  <= wdata_i;
          RI_POLL: poll_o <= wdata_i;
          default: ;
        endcase
      end
      if (rx_we_i) data_o[{rx_lane_i, 3'b000} +: BYTE_W] <= rx_byte_i;
      if (wr_i && addr_i == RI_IEN) ien_q <= wdata_i;
    end
  end

  // done flag: set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                             done_q <= 1'b0;
    else if (done_i)                                         done_q <= 1'b1;
    else if (wr_i && addr_i == RI_IST && wdata_i[B_DONE])    done_q <= 1'b0;
  end

  assign ctrl_o     = ctrl_q;
  assign irq_o      = done_q & ien_q[B_DONE] & ien_q[0];
  assign unused_ien = ^{ien_q[WORD_W-1:6], ien_q[4:1]};

  always_comb begin
    case (addr_i)
      RI_CTRL: rdata_o = {busy_i, ctrl_q[WORD_W-2:0]};
      RI_OP1:  rdata_o = {24'd0, op1_o};
      RI_OP2:  rdata_o = {24'd0, op2_o};
      RI_ALO:  rdata_o = alo_o;
      RI_AHI:  rdata_o = ahi_o;
      RI_DATA: rdata_o = data_o;
      RI_TIM:  rdata_o = tim_o;
      RI_POLL: rdata_o = poll_o;
      RI_IST:  rdata_o = {26'd0, done_q, 5'd0};
      RI_IEN:  rdata_o = ien_q;
      default: rdata_o = '0;
    endcase
  end

  p_done_sets_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> done_q);
  p_ctrl_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && wr_i && addr_i == RI_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
  import nand_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] start_word_i,
  input  logic [BYTE_W-1:0] op1_i,
  input  logic [BYTE_W-1:0] op2_i,
  input  logic [WORD_W-1:0] alo_i,
  input  logic [WORD_W-1:0] ahi_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic [WORD_W-1:0] tim_i,
  input  logic [WORD_W-1:0] poll_i,
  input  logic [BYTE_W-1:0] io_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rx_we_o,
  output logic [1:0]        rx_lane_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic [CE_W-1:0]   ce_no,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [BYTE_W-1:0] io_o,
  output logic              io_oe_o
);
  localparam int CNT_W = 8;

  ph_e               ph_q, ph_d, tgt;
  rs_e               sub_q, sub_d;
  logic [WORD_W-1:0] cw_q, cw_d;
  logic [3:0]        bidx_q, bidx_d;
  logic              half_q, half_d, go, adv;
  logic [CNT_W-1:0]  tcnt_q, tcnt_d;
  logic [BYTE_W-1:0] stat_q, stat_d;
  logic [CNT_W-1:0]  wl, wh, rl, rh, wb, gap, lo_len, hi_len;
  logic              is_wr, is_rd, pause;
  logic [1:0]        dlast;
  logic [63:0]       aw;
  logic              unused_bits;

  assign wl  = {4'd0, tim_i[11:8]};
  assign wh  = {6'd0, tim_i[13:12]};
  assign rl  = {4'd0, tim_i[3:0]};
  assign rh  = {4'd0, tim_i[7:4]};
  assign wb  = {4'd0, tim_i[27:24]};
  assign gap = poll_i[31:24];
  assign aw  = {ahi_i, alo_i};
  assign dlast = (cw_q[23:20] > 4'd3) ? 2'd3 : cw_q[21:20];
  assign unused_bits = ^{tim_i[31:28], tim_i[23:14], cw_q[31:26], cw_q[19:17], cw_q[7:4]};

  assign is_wr = (ph_q == PH_CMD1) || (ph_q == PH_ADDR) || (ph_q == PH_CMD2)
              || (ph_q == PH_DATA && cw_q[B_TX]) || (ph_q == PH_RDY && sub_q == RS_CMD);
  assign is_rd = (ph_q == PH_DATA && !cw_q[B_TX]) || (ph_q == PH_RDY && sub_q == RS_READ);
  assign pause = (ph_q == PH_RDY) && (sub_q == RS_WAIT || sub_q == RS_GAP);
  assign lo_len = is_rd ? rl : wl;
  assign hi_len = is_rd ? rh : wh;

  always_comb begin
    ph_d = ph_q; cw_d = cw_q; bidx_d = bidx_q; half_d = half_q;
    tcnt_d = tcnt_q; sub_d = sub_q; stat_d = stat_q;
    done_o = 1'b0; rx_we_o = 1'b0; go = 1'b0; adv = 1'b0; tgt = PH_DONE;
    case (ph_q)
      PH_IDLE: if (start_i) begin
        cw_d = start_word_i; go = 1'b1; tgt = ph_next(PH_IDLE, start_word_i);
      end
      PH_DONE: begin done_o = 1'b1; ph_d = PH_IDLE; end
      default: begin
        if (tcnt_q != '0) tcnt_d = tcnt_q - 1'b1;
        else if (pause) begin
          sub_d = RS_CMD; half_d = 1'b0; tcnt_d = wl;
        end else if (!half_q) begin
          half_d = 1'b1; tcnt_d = hi_len;
          if (is_rd && ph_q == PH_DATA) rx_we_o = 1'b1;
          if (is_rd && ph_q == PH_RDY)  stat_d  = io_i;
        end else begin
          half_d = 1'b0; tcnt_d = lo_len;
          case (ph_q)
            PH_ADDR: if (bidx_q == cw_q[3:0]) adv = 1'b1; else bidx_d = bidx_q + 1'b1;
            PH_DATA: if (bidx_q[1:0] == dlast) adv = 1'b1; else bidx_d = bidx_q + 1'b1;
            PH_RDY: begin
              if (sub_q == RS_CMD) begin sub_d = RS_READ; tcnt_d = rl; end
              else if ((stat_q & poll_i[15:8]) == poll_i[7:0]) adv = 1'b1;
              else begin sub_d = RS_GAP; tcnt_d = gap; end
            end
            default: adv = 1'b1;
          endcase
        end
        if (adv) begin go = 1'b1; tgt = ph_next(ph_q, cw_q); end
      end
    endcase
    if (go) begin
      ph_d = tgt; bidx_d = '0; half_d = 1'b0; sub_d = RS_WAIT;
      tcnt_d = (tgt == PH_RDY) ? wb : (tgt == PH_DATA && !cw_d[B_TX]) ? rl : wl;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= PH_IDLE; sub_q <= RS_WAIT; cw_q <= '0; bidx_q <= '0;
      half_q <= 1'b0; tcnt_q <= '0; stat_q <= '0;
    end else begin
      ph_q <= ph_d; sub_q <= sub_d; cw_q <= cw_d; bidx_q <= bidx_d;
      half_q <= half_d; tcnt_q <= tcnt_d; stat_q <= stat_d;
    end
  end

  always_comb begin
    case (ph_q)
      PH_CMD1: io_o = op1_i;
      PH_CMD2: io_o = op2_i;
      PH_ADDR: io_o = bidx_q[3] ? 8'h00 : aw[{bidx_q[2:0], 3'b000} +: BYTE_W];
      PH_DATA: io_o = data_i[{bidx_q[1:0], 3'b000} +: BYTE_W];
      PH_RDY:  io_o = poll_i[23:16];
      default: io_o = 8'h00;
    endcase
  end

  assign busy_o    = (ph_q != PH_IDLE);
  assign ce_no     = (ph_q == PH_IDLE || ph_q == PH_DONE) ? '1 : ~cw_q[CE_LSB +: CE_W];
  assign cle_o     = (ph_q == PH_CMD1) || (ph_q == PH_CMD2) || (ph_q == PH_RDY && sub_q == RS_CMD);
  assign ale_o     = (ph_q == PH_ADDR);
  assign we_no     = !(is_wr && !half_q);
  assign re_no     = !(is_rd && !half_q);
  assign io_oe_o   = is_wr;
  assign rx_lane_o = bidx_q[1:0];
  assign rx_byte_o = io_i;

  p_idle_pins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (we_no && re_no && !cle_o && !ale_o && !io_oe_o && ce_no == '1));
  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!we_no && !re_no));
  p_latch_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o));
  p_drive_on_we_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> io_oe_o);
  p_float_on_re_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_no |-> !io_oe_o);
  p_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic [7:0]        ce_no,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [7:0]        io_o,
  output logic              io_oe_o,
  input  logic [7:0]        io_i,
  output logic              irq_o
);
  logic              busy, done, start, rx_we;
  logic [1:0]        rx_lane;
  logic [BYTE_W-1:0] rx_byte, op1, op2;
  logic [WORD_W-1:0] ctrl, alo, ahi, data, tim, poll;
  logic              unused_ctrl;

  assign unused_ctrl = ^ctrl;

  nand_seq_regs u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .done_i(done),
    .rx_we_i(rx_we), .rx_lane_i(rx_lane), .rx_byte_i(rx_byte),
    .start_o(start), .ctrl_o(ctrl), .op1_o(op1), .op2_o(op2),
    .alo_o(alo), .ahi_o(ahi), .data_o(data), .tim_o(tim), .poll_o(poll),
    .irq_o
  );

  nand_seq_fsm u_fsm (
    .clk_i, .rst_ni,
    .start_i(start), .start_word_i(reg_wdata_i),
    .op1_i(op1), .op2_i(op2), .alo_i(alo), .ahi_i(ahi), .data_i(data),
    .tim_i(tim), .poll_i(poll), .io_i,
    .busy_o(busy), .done_o(done),
    .rx_we_o(rx_we), .rx_lane_o(rx_lane), .rx_byte_o(rx_byte),
    .ce_no, .cle_o, .ale_o, .we_no, .re_no, .io_o, .io_oe_o
  );
endmodule

// File: tb/nand_seq_bench.sv
`timescale 1ns/1ps
module nand_seq_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic [7:0]  ce_n, io_o, io_i;
  logic        cle, ale, we_n, re_n, io_oe, irq;
  int          checks = 0;
  int          errors = 0;

  logic [7:0]  resp [0:7];
  logic [2:0]  ridx = 3'd0;
  logic [9:0]  logv [0:63];
  int          log_n = 0;
  logic        clr_tog = 1'b0, seen_tog = 1'b0, pwe = 1'b1, pre = 1'b1;

  always #2 clk = ~clk;

  nand_seq u_nand_seq (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ce_no(ce_n), .cle_o(cle),
    .ale_o(ale), .we_no(we_n), .re_no(re_n), .io_o(io_o), .io_oe_o(io_oe),
    .io_i(io_i), .irq_o(irq)
  );

  assign io_i = resp[ridx];

  // device model: logs each byte at the rising strobe; kind 1=opcode 2=address 0=data 3=read
  always @(negedge clk) begin
    if (clr_tog != seen_tog) begin
      seen_tog <= clr_tog; log_n <= 0; ridx <= 3'd0;
    end else begin
      if (we_n && !pwe && log_n < 64) begin
        logv[log_n] <= {cle ? 2'd1 : ale ? 2'd2 : 2'd0, io_o}; log_n <= log_n + 1;
      end
      if (re_n && !pre && log_n < 64) begin
        logv[log_n] <= {2'd3, 8'h00}; log_n <= log_n + 1; ridx <= ridx + 3'd1;
      end
    end
    pwe <= we_n; pre <= re_n;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_log(input string tag, input int i, input logic [1:0] k, input logic [7:0] b);
    chk(tag, {22'd0, logv[i]}, {22'd0, k, b});
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0; addr = 4'd0; #1;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1; v = rdata; addr = 4'd0; #1;
  endtask

  task automatic wait_idle;
    for (int i = 0; i < 5000; i++) begin
      if (!rdata[31]) break;
      @(negedge clk); #1;
    end
  endtask

  task automatic clr_log;
    clr_tog = ~clr_tog; @(negedge clk); @(negedge clk); #1;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 idle pins", {ce_n, we_n, re_n, cle, ale, io_oe, irq}, {8'hFF, 6'b110000});
    do_rd(4'd0, v); chk("R1 ctrl reset", v, 32'h0);
    do_rd(4'd7, v); chk("R1 pattern default", v, 32'h0070_0000);
  endtask

  task automatic t_start_only;
    logic [31:0] v;
    clr_log;
    do_wr(4'd0, 32'h8000_0000);
    @(negedge clk); #1;
    do_rd(4'd8, v); chk("R12 done after start-only", v, 32'h20);
    chk("R12 no strobes", log_n, 0);
    do_rd(4'd0, v); chk("R2 start self-clears", v[31], 1'b0);
    chk("R10 irq masked", irq, 1'b0);
    do_wr(4'd9, 32'h21); chk("R10 irq enabled", irq, 1'b1);
    do_wr(4'd8, 32'h20); do_rd(4'd8, v);
    chk("R10 w1c clears", v, 32'h0); chk("R10 irq drops", irq, 1'b0);
  endtask

  task automatic t_normal;
    logic [31:0] v;
    do_wr(4'd6, 32'h0); do_wr(4'd1, 32'h05); do_wr(4'd2, 32'hE0);
    do_wr(4'd3, 32'h0403_0201); do_wr(4'd5, 32'h0000_BEEF);
    do_wr(4'd7, 32'h0A70_4040);
    resp[0] = 8'h00; resp[1] = 8'h41;
    clr_log;
    do_wr(4'd0, 32'hFA11_0402);
    chk("R13 ce select", ce_n, 8'hFB);
    do_rd(4'd0, v); chk("R2 busy readback", v[31], 1'b1);
    wait_idle;
    chk("R5 event count", log_n, 11);
    chk_log("R5 op1", 0, 2'd1, 8'h05);
    chk_log("R4 addr0", 1, 2'd2, 8'h01);
    chk_log("R4 addr1", 2, 2'd2, 8'h02);
    chk_log("R4 addr2", 3, 2'd2, 8'h03);
    chk_log("R5 op2", 4, 2'd1, 8'hE0);
    chk_log("R9 status op", 5, 2'd1, 8'h70);
    chk_log("R9 read", 6, 2'd3, 8'h00);
    chk_log("R9 status op again", 7, 2'd1, 8'h70);
    chk_log("R5 data0", 9, 2'd0, 8'hEF);
    chk_log("R7 data1", 10, 2'd0, 8'hBE);
    chk("R13 ce idle", ce_n, 8'hFF);
  endtask

  task automatic t_after;
    do_wr(4'd1, 32'h80); do_wr(4'd2, 32'h10);
    do_wr(4'd3, 32'h4433_2211); do_wr(4'd4, 32'h0000_0055);
    do_wr(4'd5, 32'hD4C3_B2A1); do_wr(4'd7, 32'h0070_0101);
    resp[0] = 8'h01;
    clr_log;
    do_wr(4'd0, 32'hFB51_0104);
    wait_idle;
    chk("R6 event count", log_n, 13);
    chk_log("R6 op1", 0, 2'd1, 8'h80);
    chk_log("R4 byte3 from low word", 4, 2'd2, 8'h44);
    chk_log("R4 byte4 from high word", 5, 2'd2, 8'h55);
    chk_log("R7 first data", 6, 2'd0, 8'hA1);
    chk_log("R7 fourth data clamp", 9, 2'd0, 8'hD4);
    chk_log("R6 op2 after data", 10, 2'd1, 8'h10);
    chk_log("R6 status op last", 11, 2'd1, 8'h70);
    chk_log("R6 read last", 12, 2'd3, 8'h00);
  endtask

  task automatic t_rx;
    logic [31:0] v;
    int lo, runs;
    logic prev;
    lo = 0; runs = 0; prev = 1'b1;
    do_wr(4'd6, 32'h12); do_wr(4'd1, 32'h00); do_wr(4'd5, 32'hAABB_CCDD);
    resp[0] = 8'h11; resp[1] = 8'h22; resp[2] = 8'h33;
    clr_log;
    do_wr(4'd0, 32'hD420_0200);
    for (int i = 0; i < 200; i++) begin
      if (!rdata[31]) break;
      if (!re_n) lo++;
      if (!re_n && prev) runs++;
      prev = re_n;
      @(negedge clk); #1;
    end
    chk("R8 re low cycles", lo, 9);
    chk("R8 re low runs", runs, 3);
    chk("R8 event count", log_n, 4);
    do_rd(4'd5, v); chk("R8 lanes", v, 32'hAA33_2211);
  endtask

  task automatic t_timing;
    int lo, runs, hi_gap, pend;
    logic prev, seen;
    lo = 0; runs = 0; hi_gap = 0; pend = 0; prev = 1'b1; seen = 1'b0;
    do_wr(4'd6, 32'h2300); do_wr(4'd1, 32'h90); do_wr(4'd3, 32'h0000_3412);
    clr_log;
    do_wr(4'd0, 32'hE000_0101);
    for (int i = 0; i < 200; i++) begin
      if (!rdata[31]) break;
      if (!we_n) begin
        lo++;
        if (prev) begin runs++; hi_gap += pend; pend = 0; end
        seen = 1'b1;
      end else if (seen) pend++;
      prev = we_n;
      @(negedge clk); #1;
    end
    chk("R3 we low cycles", lo, 12);
    chk("R3 we low runs", runs, 3);
    chk("R3 we high between bytes", hi_gap, 6);
    chk_log("R3 cle on opcode", 0, 2'd1, 8'h90);
    chk_log("R3 ale on address", 2, 2'd2, 8'h34);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    do_wr(4'd6, 32'h0); do_wr(4'd5, 32'hCAFE_F00D); do_wr(4'd7, 32'h0270_4040);
    resp[0] = 8'h00; resp[1] = 8'h00; resp[2] = 8'h80; resp[3] = 8'h40;
    clr_log;
    do_wr(4'd0, 32'h8001_0100);
    do_wr(4'd0, 32'hE000_0203);
    do_wr(4'd5, 32'h1234_5678);
    do_rd(4'd0, v); chk("R11 ctrl kept while busy", v, 32'h8001_0100);
    wait_idle;
    do_rd(4'd5, v); chk("R11 data kept while busy", v, 32'hCAFE_F00D);
    repeat (5) @(negedge clk);
    chk("R9 four poll rounds", log_n, 8);
    chk_log("R9 last read", 7, 2'd3, 8'h00);
    do_rd(4'd0, v); chk("R2 idle after poll", v, 32'h0001_0100);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) resp[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    t_reset;
    t_start_only;
    t_normal;
    t_after;
    t_rx;
    t_timing;
    t_busy;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule